// File: doc/BRIEF.md
# Two-level vectored interrupt controller

This block arbitrates five interrupt request lines (two external pins, two timer overflows and one serial port) for a small 8-bit processor core. Software sets an enable byte and a priority byte. Once per machine cycle the controller takes a snapshot of the request lines. At the next machine-cycle strobe it polls that snapshot and picks at most one request. It then issues a one-cycle acknowledge that carries the 16-bit address of that source's service routine. The core performs the hardware long-call and pushes only the program counter. Clearing the request flag belongs to the peripheral or to software.

Two priority levels exist, and each has its own in-progress flag. When a source is acknowledged, the flag for its level is set. A return-from-interrupt pulse from the core clears the flag of the level now being serviced. A low-level handler can be interrupted only by a high-level request. A high-level handler cannot be interrupted at all.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `ack_o` is 0, `vec_o` is 0000h, both in-progress flags are clear, and the enable and priority registers are 00h.
- R2: A request present at a strobe edge is only sampled there. It is polled at the following strobe edge, and `ack_o` is high for exactly the one clock after that edge. No acknowledge appears in any other cycle.
- R3: Source indices are 0 external-0, 1 timer-0, 2 external-1, 3 timer-1, 4 serial. The vector for index i is 0003h + 8·i, which gives 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R4: Enable register bit i (0–4) enables source i, and bit 7 is a global enable. When bit 7 is 0, or a source's own bit is 0, that source is never acknowledged.
- R5: Priority register bit i (0–4) set to 1 puts source i at the high level. Set to 0, the source is at the low level.
- R6: If high-level and low-level requests are eligible together, a high-level one is acknowledged.
- R7: Among eligible requests of one level, the lowest index wins.
- R8: While only the low in-progress flag is set, low-level requests are blocked and high-level requests are still acknowledged.
- R9: While the high in-progress flag is set, no request is acknowledged.
- R10: An acknowledge sets the in-progress flag of the granted source's level.
- R11: A `reti_i` pulse clears the high in-progress flag if it is set, and otherwise clears the low one. Nothing else clears either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 5 | Request flags, index order as in R3 |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register value (bit 7 global, bits 0–4 per source) |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register value (bits 0–4, 1 = high) |
| cyc_stb | input | 1 | One-clock pulse marking each machine-cycle boundary |
| reti_i | input | 1 | Return-from-interrupt pulse |
| ack_o | output | 1 | One-clock acknowledge |
| vec_o | output | 16 | Service routine address, valid while `ack_o` is high |

## Verification
An acknowledge is due one clock after the second strobe that follows a request. The first strobe latches the request, and the second polls it into the output register. So after each strobe edge the bench compares `ack_o` and `vec_o` against a decision taken from the snapshot stored at the previous strobe. The bench reads `ack_o` again one clock later, where it must be low. Register writes and `reti_i` take effect at their own clock edge. The bench issues them as separate cycles between strobes, so its model of the enables, priorities and in-progress flags is up to date before the next poll is predicted.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the vectored interrupt controller.
// Assumes source index order is the tie-break order within a level.
package irq_pkg;
    localparam int NSRC     = 5;
    localparam int IDX_W    = $clog2(NSRC);
    localparam int REG_W    = 8;
    localparam int GLB_BIT  = REG_W - 1;
    localparam int ADDR_W   = 16;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0] src_idx_t;

    // Returns the lowest set index of a non-empty candidate vector.
    function automatic src_idx_t first_set(input src_vec_t v);
        src_idx_t r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_idx_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_sampler.sv
// Request snapshot register: captures the request lines at each
// machine-cycle strobe so the poll in the next cycle sees a stable set.
// Assumes cyc_stb is a single-clock pulse.
module irq_sampler #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [N-1:0] req,
    output logic [N-1:0] snap
);
    // Latch the request lines once per machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   snap <= '0;
        else if (stb) snap <= req;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational poll: qualifies the snapshot with enables and the
// in-progress flags, then picks high level first, lowest index next.
// Assumes en carries the global enable in its top bit.
module irq_arbiter
    import irq_pkg::*;
(
    input  src_vec_t       snap,
    input  logic [REG_W-1:0] en,
    input  src_vec_t       pri,
    input  logic           hip,
    input  logic           lip,
    output logic           grant,
    output logic           grant_hi,
    output src_idx_t       grant_idx
);
    src_vec_t elig, hi_cand, lo_cand;

    // Form eligible candidates per level and select one winner.
    always_comb begin
        elig      = snap & en[NSRC-1:0] & {NSRC{en[GLB_BIT]}};
        hi_cand   = elig & pri & {NSRC{~hip}};
        lo_cand   = elig & ~pri & {NSRC{~hip & ~lip}};
        grant_hi  = |hi_cand;
        grant     = grant_hi | (|lo_cand);
        grant_idx = grant_hi ? first_set(hi_cand) : first_set(lo_cand);
    end
endmodule

// File: rtl/irq_level_state.sv
// Per-level in-progress flags. A grant sets its level's flag; a return
// clears the highest level in service. Assumes return and grant do
// not coincide; if they do, the clear is applied before the set.
module irq_level_state (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic set_hi,
    input  logic ret,
    output logic hip,
    output logic lip
);
    logic hip_n, lip_n;

    // Next-state: clear on return (high first), then apply a grant.
    always_comb begin
        hip_n = hip;
        lip_n = lip;
        if (ret) begin
            if (hip) hip_n = 1'b0;
            else     lip_n = 1'b0;
        end
        if (set_en) begin
            if (set_hi) hip_n = 1'b1;
            else        lip_n = 1'b1;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hip <= 1'b0;
            lip <= 1'b0;
        end else begin
            hip <= hip_n;
            lip <= lip_n;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Two-level vectored interrupt controller top. Holds the enable and
// priority registers, samples requests each machine cycle, polls the
// previous snapshot at the next strobe and emits a one-clock
// acknowledge with the vector address. Assumes cyc_stb is a pulse.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0003,
    parameter int                VEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic              en_we,
    input  logic [REG_W-1:0]  en_wdata,
    input  logic              pri_we,
    input  logic [REG_W-1:0]  pri_wdata,
    input  logic              cyc_stb,
    input  logic              reti_i,
    output logic              ack_o,
    output logic [ADDR_W-1:0] vec_o
);
    logic [REG_W-1:0] en_q;
    src_vec_t         pri_q;
    src_vec_t         snap;
    logic             hip_q, lip_q;
    logic             grant, grant_hi;
    src_idx_t         grant_idx;
    logic             take;

    // Software-written enable and priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (pri_we) pri_q <= pri_wdata[NSRC-1:0];
        end
    end

    irq_sampler #(.N(NSRC)) u_samp (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (cyc_stb),
        .req  (req_i),
        .snap (snap)
    );

    irq_arbiter u_arb (
        .snap     (snap),
        .en       (en_q),
        .pri      (pri_q),
        .hip      (hip_q),
        .lip      (lip_q),
        .grant    (grant),
        .grant_hi (grant_hi),
        .grant_idx(grant_idx)
    );

    assign take = cyc_stb & grant;

    irq_level_state u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(take),
        .set_hi(grant_hi),
        .ret   (reti_i),
        .hip   (hip_q),
        .lip   (lip_q)
    );

    // Acknowledge register: one-clock pulse carrying the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            vec_o <= '0;
        end else begin
            ack_o <= take;
            if (take)
                vec_o <= VEC_BASE + ADDR_W'(grant_idx) * ADDR_W'(VEC_STRIDE);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Assertion checker for irq_vector_ctrl, attached with bind.
// Observes ports plus the global enable and in-progress flags.
module irq_vector_ctrl_chk #(
    parameter int NSRC     = 5,
    parameter int VBASE    = 3,
    parameter int VSTRIDE  = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_stb,
    input logic        ack_o,
    input logic [15:0] vec_o,
    input logic        glob_en,
    input logic        hip,
    input logic        lip
);
    localparam int VMAX = VBASE + VSTRIDE * (NSRC - 1);

    assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cyc_stb));

    assert_vector_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ((int'(vec_o) - VBASE) % VSTRIDE == 0 && int'(vec_o) <= VMAX
                   && int'(vec_o) >= VBASE));

    assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(glob_en));

    assert_low_busy_high_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(lip) && !$past(hip)) |-> hip);

    assert_high_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !$past(hip));

    assert_ack_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (hip || lip));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc_stb(cyc_stb),
    .ack_o  (ack_o),
    .vec_o  (vec_o),
    .glob_en(en_q[7]),
    .hip    (hip_q),
    .lip    (lip_q)
);

// File: tb/tb_irq_vector_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random
// traffic, compared against a behavioural model kept in the bench.
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  req_i = '0;
    logic        en_we = 1'b0, pri_we = 1'b0, cyc_stb = 1'b0, reti_i = 1'b0;
    logic [7:0]  en_wdata = '0, pri_wdata = '0;
    logic        ack_o;
    logic [15:0] vec_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Bench model state.
    logic [7:0] m_en = '0;
    logic [4:0] m_pri = '0;
    logic [4:0] m_snap = '0;
    logic       m_hip = 1'b0, m_lip = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .en_we(en_we), .en_wdata(en_wdata),
        .pri_we(pri_we), .pri_wdata(pri_wdata),
        .cyc_stb(cyc_stb), .reti_i(reti_i),
        .ack_o(ack_o), .vec_o(vec_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model poll: returns found, level and index from current model state.
    function automatic void poll(output bit found, output bit hi, output int idx);
        logic [4:0] elig, hc, lc;
        elig  = m_snap & m_en[4:0] & {5{m_en[7]}};
        hc    = m_hip ? 5'b0 : (elig & m_pri);
        lc    = (m_hip || m_lip) ? 5'b0 : (elig & ~m_pri);
        found = 1'b0; hi = 1'b0; idx = 0;
        for (int i = 4; i >= 0; i--) if (lc[i]) begin found = 1'b1; idx = i; end
        for (int i = 4; i >= 0; i--) if (hc[i]) begin found = 1'b1; hi = 1'b1; idx = i; end
    endfunction

    task automatic wr_en(input logic [7:0] v);
        @(negedge clk); en_we = 1'b1; en_wdata = v;
        @(negedge clk); en_we = 1'b0;
        m_en = v;
    endtask

    task automatic wr_pri(input logic [7:0] v);
        @(negedge clk); pri_we = 1'b1; pri_wdata = v;
        @(negedge clk); pri_we = 1'b0;
        m_pri = v[4:0];
    endtask

    task automatic do_reti();
        @(negedge clk); reti_i = 1'b1;
        @(negedge clk); reti_i = 1'b0;
        if (m_hip) m_hip = 1'b0; else m_lip = 1'b0;
    endtask

    // One machine-cycle strobe with request pattern r; checks the poll
    // result one clock after the edge and the pulse end one clock later.
    task automatic mcycle(input logic [4:0] r, input string tag);
        bit f, h; int ix;
        poll(f, h, ix);
        @(negedge clk); req_i = r; cyc_stb = 1'b1;
        @(posedge clk); #1;
        check({tag, " ack"}, 32'(ack_o), 32'(f));
        if (f) begin
            check({tag, " vec"}, 32'(vec_o), 32'(16'h0003 + 16'(ix) * 16'd8));
            if (h) m_hip = 1'b1; else m_lip = 1'b1;
        end
        m_snap = r;
        @(negedge clk); cyc_stb = 1'b0;
        @(posedge clk); #1;
        check("R2 pulse ends", 32'(ack_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        #1;
        check("R1 ack reset", 32'(ack_o), 32'd0);
        check("R1 vec reset", 32'(vec_o), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: registers 00h, so a request is never acknowledged.
        mcycle(5'h1F, "R1");
        mcycle(5'h1F, "R1");
        mcycle(5'h00, "R1");

        // R2: one strobe latches, the next polls.
        wr_en(8'h9F);
        mcycle(5'h04, "R2 latch");
        mcycle(5'h00, "R2 poll");       // EX1 at 0013h, low level
        // R10 low flag set: a low request is now blocked (R8).
        mcycle(5'h01, "R8 low blocked");
        mcycle(5'h00, "R8 low blocked");
        do_reti();                       // R11 clears low
        // R7 + R3 serial vector: only serial pending.
        mcycle(5'h10, "R3");
        mcycle(5'h00, "R3 serial 0023h");
        do_reti();
        // R7: all five at low level, lowest index wins.
        mcycle(5'h1F, "R7");
        mcycle(5'h00, "R7 all low");
        // R8: low in service, high request preempts (R5 sets ET1 high).
        wr_pri(8'h08);
        mcycle(5'h0A, "R8");
        mcycle(5'h00, "R8 preempt");
        // R9: high in service blocks everything.
        mcycle(5'h1F, "R9");
        mcycle(5'h00, "R9 blocked");
        do_reti();                       // R11 clears high first
        mcycle(5'h01, "R11 low still set");
        mcycle(5'h00, "R11 low still set");
        do_reti();                       // clears low
        // R6: high and low together, high wins.
        wr_pri(8'h10);
        mcycle(5'h11, "R6");
        mcycle(5'h00, "R6 high wins");
        do_reti();
        // R4: global disable and per-source disable.
        wr_en(8'h1F);
        mcycle(5'h1F, "R4 global off");
        mcycle(5'h00, "R4 global off");
        wr_en(8'h82);
        mcycle(5'h1D, "R4 source off");
        mcycle(5'h00, "R4 source off");

        // Random traffic mixed with register writes and returns.
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      wr_en({$urandom_range(0, 3) != 0, 2'b00, 5'($urandom)});
            else if (sel == 1) wr_pri(8'($urandom));
            else if (sel <= 3) begin
                if (m_hip || m_lip) do_reti();
            end else
                mcycle(5'($urandom) & 5'($urandom), "R6 R7 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule